// File: doc/BRIEF.md
# Multi-Antenna Frequency-Domain Pattern Correlator

This block measures how well a received frequency-domain segment matches each cyclic delay of a known training sequence. Four antennas each deliver a vector of sixteen complex bins once per segment. A one-cycle `start` pulse presents the vector. The block then walks through sixteen stored delay patterns. For each pattern it sums, over all bins and all antennas, the received bin multiplied by the stored coefficient. The stored table already holds conjugated values, so no conjugation happens at run time. The complex total is reduced to its squared magnitude before it leaves the block.

Each antenna has four complex multipliers. They are reused over four clock cycles to cover the sixteen bins, so one pattern takes four cycles and a full segment takes sixteen patterns times four cycles, sixty-four cycles. At four times the sample rate this fits one segment period. Results leave one at a time as (delay index, metric) pairs with a valid strobe, in ascending delay order. A `done` pulse follows the last pair. A downstream sorter or path search consumes this stream.

Top module: `fd_pattern_correlator`

## Requirements
- R1: A `start` pulse seen while no run is in progress captures the whole of `rx_vec` on that edge. Element e = a*16+n (antenna a, bin n) carries its real part at bits [e*24 +: 12] and its imaginary part at bits [e*24+12 +: 12], both two's complement. Changes on `rx_vec` after that edge have no effect on the run's results.
- R2: The coefficient for delay d and bin n is conj(S[n]) * T(k), with k = (n*d) mod 16. S[n] has real part +1 when bit n of 16'h9A5D is set and -1 otherwise, and imaginary part +1 when bit n of 16'h3C6B is set and -1 otherwise. T(k) = round(511*cos(2*pi*k/16)) + j*round(511*sin(2*pi*k/16)).
- R3: The metric for delay d is exactly Re^2 + Im^2 of the sum over the four antennas and sixteen bins of rx[a][n] times coefficient(d,n). It must not overflow, even with every input component at -2048.
- R4: The sixteen results of a run appear in ascending delay order 0 to 15, one index per valid strobe.
- R5: Take the accepting edge as cycle 0. `out_valid` is high for the single cycle following edge 4*d+6 for delay d, and low in every other cycle.
- R6: `done` is high for exactly one cycle, the cycle after the delay-15 result.
- R7: A `start` on any of the 64 edges after an accepting edge is ignored. A `start` on the 65th edge is accepted.
- R8: While `rst_n` is low, `out_valid`, `done`, `out_idx` and `out_metric` are zero. A run interrupted by reset emits nothing afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock (four times the sample rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse: a new segment vector is present on `rx_vec` |
| rx_vec | input | 1536 | Four antennas by sixteen complex bins, 12-bit real and imaginary parts |
| out_valid | output | 1 | Strobe for one (index, metric) pair |
| out_idx | output | 4 | Delay index of the current pair |
| out_metric | output | 60 | Squared magnitude of the antenna-combined correlation |
| done | output | 1 | Pulse one cycle after the last pair of a run |

## Verification
The bench drives several kinds of vectors, and each one exposes a different class of fault:
- A vector built as the conjugate of the delay-5 pattern on every antenna gives one dominant peak. A wrong coefficient, index order or conjugation moves or flattens that peak.
- A single nonzero bin on one antenna isolates a single table entry and one bin lane of the multiplexer.
- A full-scale negative vector checks accumulator and squaring headroom.
- Pseudo-random vectors give every bin and antenna a distinct value, so swapped or dropped terms show up.

Further runs cover these cases:
- `rx_vec` changes in mid-run.
- `start` arrives while a run is in progress, including on the last edge before it can be accepted.
- Back-to-back runs.
- Reset arrives in mid-run.

// File: rtl/fdpc_pkg.sv
package fdpc_pkg;

   localparam int TWID_PTS = 16;
   localparam int TWID_AMP = 511;
   localparam logic [15:0] SEED_SIGN_RE = 16'h9A5D;
   localparam logic [15:0] SEED_SIGN_IM = 16'h3C6B;

   // quantized amplitude of one quarter of the unit circle, r = 0..4
   function automatic int quarter_amp(input int r);
      case (r)
         0:       return TWID_AMP;
         1:       return 472;
         2:       return 361;
         3:       return 196;
         default: return 0;
      endcase
   endfunction

   function automatic int twid_cos(input int k);
      int kk;
      kk = k % TWID_PTS;
      if (kk <= 4)       return quarter_amp(kk);
      else if (kk <= 8)  return -quarter_amp(8 - kk);
      else if (kk <= 12) return -quarter_amp(kk - 8);
      else               return quarter_amp(16 - kk);
   endfunction

   function automatic int twid_sin(input int k);
      return twid_cos((k + 12) % TWID_PTS);
   endfunction

   function automatic int seed_sign(input logic [15:0] mask, input int n);
      return mask[n] ? 1 : -1;
   endfunction

   // stored value = conj(seed[n]) * twiddle((n*d) mod 16)
   function automatic int coef_re(input int d, input int n);
      int k;
      k = (n * d) % TWID_PTS;
      return seed_sign(SEED_SIGN_RE, n) * twid_cos(k) + seed_sign(SEED_SIGN_IM, n) * twid_sin(k);
   endfunction

   function automatic int coef_im(input int d, input int n);
      int k;
      k = (n * d) % TWID_PTS;
      return seed_sign(SEED_SIGN_RE, n) * twid_sin(k) - seed_sign(SEED_SIGN_IM, n) * twid_cos(k);
   endfunction

endpackage

// File: rtl/fdpc_rom.sv
module fdpc_rom #(
   parameter int NPAT = 16,
   parameter int NBIN = 16,
   parameter int NMUL = 4,
   parameter int CW   = 11,
   parameter int IW   = $clog2(NPAT),
   parameter int PHW  = $clog2(NBIN / NMUL)
) (
   input  logic [IW-1:0]         pat,
   input  logic [PHW-1:0]        phase,
   output logic signed [CW-1:0]  c_re [NMUL],
   output logic signed [CW-1:0]  c_im [NMUL]
);
   localparam int MSW = $clog2(NMUL);
   localparam int ADW = IW + PHW + MSW;

   logic signed [CW-1:0] tab_re [NPAT*NBIN];
   logic signed [CW-1:0] tab_im [NPAT*NBIN];

   for (genvar gd = 0; gd < NPAT; gd++) begin : g_pat
      for (genvar gn = 0; gn < NBIN; gn++) begin : g_bin
         assign tab_re[gd*NBIN + gn] = CW'(fdpc_pkg::coef_re(gd, gn));
         assign tab_im[gd*NBIN + gn] = CW'(fdpc_pkg::coef_im(gd, gn));
      end
   end

   for (genvar gm = 0; gm < NMUL; gm++) begin : g_lane
      logic [ADW-1:0] addr;
      assign addr       = {pat, phase, MSW'(gm)};
      assign c_re[gm]   = tab_re[addr];
      assign c_im[gm]   = tab_im[addr];
   end

endmodule

// File: rtl/fdpc_bank.sv
module fdpc_bank #(
   parameter int DW   = 12,
   parameter int CW   = 11,
   parameter int NMUL = 4,
   parameter int SW   = DW + CW + 1 + $clog2(NMUL)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic signed [DW-1:0] x_re [NMUL],
   input  logic signed [DW-1:0] x_im [NMUL],
   input  logic signed [CW-1:0] c_re [NMUL],
   input  logic signed [CW-1:0] c_im [NMUL],
   output logic signed [SW-1:0] s_re,
   output logic signed [SW-1:0] s_im
);
   localparam int MPW = DW + CW;
   localparam int PW  = MPW + 1;

   logic signed [PW-1:0] p_re [NMUL];
   logic signed [PW-1:0] p_im [NMUL];

   for (genvar gm = 0; gm < NMUL; gm++) begin : g_mul
      logic signed [MPW-1:0] m_rr, m_ii, m_ri, m_ir;
      assign m_rr     = MPW'(x_re[gm]) * MPW'(c_re[gm]);
      assign m_ii     = MPW'(x_im[gm]) * MPW'(c_im[gm]);
      assign m_ri     = MPW'(x_re[gm]) * MPW'(c_im[gm]);
      assign m_ir     = MPW'(x_im[gm]) * MPW'(c_re[gm]);
      assign p_re[gm] = PW'(m_rr) - PW'(m_ii);
      assign p_im[gm] = PW'(m_ri) + PW'(m_ir);
   end

   logic signed [SW-1:0] sum_re, sum_im;
   always_comb begin
      sum_re = '0;
      sum_im = '0;
      for (int m = 0; m < NMUL; m++) begin
         sum_re += SW'(p_re[m]);
         sum_im += SW'(p_im[m]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_re <= '0;
         s_im <= '0;
      end else if (en) begin
         s_re <= sum_re;
         s_im <= sum_im;
      end
   end

endmodule

// File: rtl/fdpc_power.sv
module fdpc_power #(
   parameter int AW = 30,
   parameter int IW = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_v,
   input  logic signed [AW-1:0] in_re,
   input  logic signed [AW-1:0] in_im,
   input  logic [IW-1:0]        in_idx,
   output logic                 out_valid,
   output logic [IW-1:0]        out_idx,
   output logic [2*AW-1:0]      out_metric
);
   localparam int QW = 2 * AW;

   logic signed [QW-1:0] sq_re, sq_im;
   logic [QW-1:0]        pw;

   assign sq_re = QW'(in_re) * QW'(in_re);
   assign sq_im = QW'(in_im) * QW'(in_im);
   assign pw    = sq_re + sq_im;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_idx    <= '0;
         out_metric <= '0;
      end else begin
         out_valid <= in_v;
         if (in_v) begin
            out_idx    <= in_idx;
            out_metric <= pw;
         end
      end
   end

   AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      in_v && in_re == '0 && in_im == '0 |=> out_metric == '0); // R3

endmodule

// File: rtl/fd_pattern_correlator.sv
module fd_pattern_correlator #(
   parameter int NANT = 4,
   parameter int NBIN = 16,
   parameter int NPAT = 16,
   parameter int NMUL = 4,
   parameter int DW   = 12,
   parameter int CW   = 11
) (
   input  logic                                             clk,
   input  logic                                             rst_n,
   input  logic                                             start,
   input  logic [NANT*NBIN*2*DW-1:0]                        rx_vec,
   output logic                                             out_valid,
   output logic [$clog2(NPAT)-1:0]                          out_idx,
   output logic [2*(DW+CW+1+$clog2(NBIN*NANT))-1:0]         out_metric,
   output logic                                             done
);
   localparam int NPH   = NBIN / NMUL;
   localparam int PHW   = $clog2(NPH);
   localparam int IW    = $clog2(NPAT);
   localparam int MSW   = $clog2(NMUL);
   localparam int ANTW  = $clog2(NANT);
   localparam int EW    = ANTW + PHW + MSW;
   localparam int CNTW  = IW + PHW;
   localparam int PW    = DW + CW + 1;
   localparam int SW    = PW + MSW;
   localparam int AW    = PW + $clog2(NBIN * NANT);
   localparam logic [CNTW-1:0] LASTC = '1;

   // elaboration-time parameter checks
   if (NBIN != fdpc_pkg::TWID_PTS) begin : g_bad_bin
      $error("NBIN must match the 16-point twiddle table");
   end
   if (NMUL < 2 || (NBIN % NMUL) != 0 || NPH < 2 || (NPH & (NPH - 1)) != 0) begin : g_bad_mul
      $error("NMUL must split NBIN into a power-of-two number of phases");
   end
   if (NPAT < 2 || NPAT > NBIN || (NPAT & (NPAT - 1)) != 0) begin : g_bad_pat
      $error("NPAT must be a power of two between 2 and NBIN");
   end
   if (NANT < 2 || (NANT & (NANT - 1)) != 0) begin : g_bad_ant
      $error("NANT must be a power of two of at least 2");
   end

   // ---------------- sequencer ----------------
   logic            busy;
   logic [CNTW-1:0] cnt;
   logic [IW-1:0]   pat;
   logic [PHW-1:0]  ph;

   assign pat = cnt[CNTW-1:PHW];
   assign ph  = cnt[PHW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (!busy) begin
         if (start) begin
            busy <= 1'b1;
            cnt  <= '0;
         end
      end else begin
         cnt <= cnt + CNTW'(1);
         if (cnt == LASTC) busy <= 1'b0;
      end
   end

   // ---------------- segment capture ----------------
   logic signed [DW-1:0] cap_re [NANT*NBIN];
   logic signed [DW-1:0] cap_im [NANT*NBIN];

   always_ff @(posedge clk) begin
      if (start && !busy) begin
         for (int e = 0; e < NANT*NBIN; e++) begin
            cap_re[e] <= rx_vec[e*2*DW +: DW];
            cap_im[e] <= rx_vec[e*2*DW + DW +: DW];
         end
      end
   end

   // ---------------- pattern table ----------------
   logic signed [CW-1:0] c_re [NMUL];
   logic signed [CW-1:0] c_im [NMUL];

   fdpc_rom #(.NPAT(NPAT), .NBIN(NBIN), .NMUL(NMUL), .CW(CW), .IW(IW), .PHW(PHW)) u_rom (
      .pat   (pat),
      .phase (ph),
      .c_re  (c_re),
      .c_im  (c_im)
   );

   // ---------------- antenna banks ----------------
   logic signed [DW-1:0] x_re [NANT][NMUL];
   logic signed [DW-1:0] x_im [NANT][NMUL];
   logic signed [SW-1:0] b_re [NANT];
   logic signed [SW-1:0] b_im [NANT];

   for (genvar ga = 0; ga < NANT; ga++) begin : g_ant
      for (genvar gm = 0; gm < NMUL; gm++) begin : g_sel
         logic [EW-1:0] sel;
         assign sel          = {ANTW'(ga), ph, MSW'(gm)};
         assign x_re[ga][gm] = cap_re[sel];
         assign x_im[ga][gm] = cap_im[sel];
      end
      fdpc_bank #(.DW(DW), .CW(CW), .NMUL(NMUL), .SW(SW)) u_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (busy),
         .x_re  (x_re[ga]),
         .x_im  (x_im[ga]),
         .c_re  (c_re),
         .c_im  (c_im),
         .s_re  (b_re[ga]),
         .s_im  (b_im[ga])
      );
   end

   // ---------------- stage 1 sideband ----------------
   logic          s1_v, s1_first, s1_last;
   logic [IW-1:0] s1_pat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v     <= 1'b0;
         s1_first <= 1'b0;
         s1_last  <= 1'b0;
         s1_pat   <= '0;
      end else begin
         s1_v     <= busy;
         s1_first <= (ph == '0);
         s1_last  <= (ph == PHW'(NPH - 1));
         s1_pat   <= pat;
      end
   end

   // ---------------- antenna combine and phase accumulation ----------------
   logic signed [AW-1:0] asum_re, asum_im;
   logic signed [AW-1:0] acc_re, acc_im, acc_nx_re, acc_nx_im;
   logic signed [AW-1:0] f_re, f_im;
   logic                 f_v;
   logic [IW-1:0]        f_pat;

   always_comb begin
      asum_re = '0;
      asum_im = '0;
      for (int a = 0; a < NANT; a++) begin
         asum_re += AW'(b_re[a]);
         asum_im += AW'(b_im[a]);
      end
   end

   assign acc_nx_re = (s1_first ? '0 : acc_re) + asum_re;
   assign acc_nx_im = (s1_first ? '0 : acc_im) + asum_im;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_re <= '0;
         acc_im <= '0;
         f_v    <= 1'b0;
         f_re   <= '0;
         f_im   <= '0;
         f_pat  <= '0;
      end else begin
         f_v <= s1_v && s1_last;
         if (s1_v) begin
            acc_re <= acc_nx_re;
            acc_im <= acc_nx_im;
         end
         if (s1_v && s1_last) begin
            f_re  <= acc_nx_re;
            f_im  <= acc_nx_im;
            f_pat <= s1_pat;
         end
      end
   end

   // ---------------- magnitude squared ----------------
   fdpc_power #(.AW(AW), .IW(IW)) u_power (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_v       (f_v),
      .in_re      (f_re),
      .in_im      (f_im),
      .in_idx     (f_pat),
      .out_valid  (out_valid),
      .out_idx    (out_idx),
      .out_metric (out_metric)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done <= 1'b0;
      else        done <= out_valid && (out_idx == IW'(NPAT - 1));
   end

   // ---------------- assertions ----------------
   AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(cap_re[0]) && $stable(cap_im[0])); // R1

   AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_idx != '0 |-> $past(out_idx) == out_idx - IW'(1)); // R4

   AST_VALID_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid); // R5

   AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(out_valid) && $past(out_idx) == IW'(NPAT - 1)); // R6

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start && cnt != LASTC |=> busy && cnt == $past(cnt) + CNTW'(1)); // R7

endmodule

// File: tb/tb_fd_pattern_correlator.sv
`timescale 1ns/1ps
module tb_fd_pattern_correlator;
   localparam int NANT = 4;
   localparam int NBIN = 16;
   localparam int NPAT = 16;
   localparam int DW   = 12;
   localparam int CW   = 11;
   localparam int VW   = NANT * NBIN * 2 * DW;
   localparam int MW   = 2 * (DW + CW + 1 + $clog2(NBIN * NANT));
   localparam real PI  = 3.14159265358979;

   logic          clk, rst_n, start;
   logic [VW-1:0] rx_vec;
   logic          out_valid, done;
   logic [3:0]    out_idx;
   logic [MW-1:0] out_metric;

   fd_pattern_correlator dut (
      .clk(clk), .rst_n(rst_n), .start(start), .rx_vec(rx_vec),
      .out_valid(out_valid), .out_idx(out_idx), .out_metric(out_metric), .done(done)
   );

   initial clk = 1'b0;
   always #4 clk = ~clk;

   int    checks = 0;
   int    failures = 0;
   string phase_tag = "R8";

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s [phase %s] actual=%0d expected=%0d", req, phase_tag, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   function automatic int rnd(input real x);
      return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
   endfunction

   function automatic int ref_c_re(input int d, input int n);
      int  k, sr, si, tc, ts;
      logic [15:0] mre, mim;
      mre = 16'h9A5D; mim = 16'h3C6B;
      k  = (n * d) % 16;
      sr = mre[n] ? 1 : -1;
      si = mim[n] ? 1 : -1;
      tc = rnd(511.0 * $cos(2.0 * PI * k / 16.0));
      ts = rnd(511.0 * $sin(2.0 * PI * k / 16.0));
      return sr * tc + si * ts;
   endfunction

   function automatic int ref_c_im(input int d, input int n);
      int  k, sr, si, tc, ts;
      logic [15:0] mre, mim;
      mre = 16'h9A5D; mim = 16'h3C6B;
      k  = (n * d) % 16;
      sr = mre[n] ? 1 : -1;
      si = mim[n] ? 1 : -1;
      tc = rnd(511.0 * $cos(2.0 * PI * k / 16.0));
      ts = rnd(511.0 * $sin(2.0 * PI * k / 16.0));
      return sr * ts - si * tc;
   endfunction

   function automatic longint ref_metric(input logic [VW-1:0] v, input int d);
      longint re, im;
      re = 0; im = 0;
      for (int a = 0; a < NANT; a++) begin
         for (int n = 0; n < NBIN; n++) begin
            int e, xr, xi, cr, ci;
            e  = a * NBIN + n;
            xr = $signed(v[e*2*DW +: DW]);
            xi = $signed(v[e*2*DW + DW +: DW]);
            cr = ref_c_re(d, n);
            ci = ref_c_im(d, n);
            re += longint'(xr) * cr - longint'(xi) * ci;
            im += longint'(xr) * ci + longint'(xi) * cr;
         end
      end
      return re * re + im * im;
   endfunction

   int     cyc = 0;
   int     next_ok = 0;
   bit     exp_v [int];
   int     exp_i [int];
   longint exp_m [int];
   bit     exp_d [int];

   always @(posedge clk) begin
      cyc++;
      if (rst_n && start && cyc >= next_ok) begin
         next_ok = cyc + 65;                       // R7: edges 1..64 ignored
         for (int p = 0; p < NPAT; p++) begin
            exp_v[cyc + 4*p + 6] = 1'b1;           // R5
            exp_i[cyc + 4*p + 6] = p;              // R4
            exp_m[cyc + 4*p + 6] = ref_metric(rx_vec, p);
         end
         exp_d[cyc + 67] = 1'b1;                   // R6
      end
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         chk(out_valid == 1'b0, "R8", longint'(out_valid), 0);
         chk(done == 1'b0, "R8", longint'(done), 0);
         chk(out_idx == '0, "R8", longint'(out_idx), 0);
         chk(out_metric == '0, "R8", longint'(out_metric), 0);
         exp_v.delete(); exp_i.delete(); exp_m.delete(); exp_d.delete();
         next_ok = 0;
      end else begin
         bit ev, ed;
         ev = exp_v.exists(cyc);
         ed = exp_d.exists(cyc);
         chk(out_valid == ev, "R5", longint'(out_valid), longint'(ev));
         chk(done == ed, "R6", longint'(done), longint'(ed));
         if (ev) begin
            chk(int'(out_idx) == exp_i[cyc], "R4", longint'(out_idx), longint'(exp_i[cyc]));
            chk(longint'(out_metric) == exp_m[cyc], "R2 R3", longint'(out_metric), exp_m[cyc]);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   int unsigned seed = 32'h1234_5678;

   function automatic int rand12();
      seed = seed * 32'd1103515245 + 32'd12345;
      return int'((seed >> 8) & 32'hFFF) - 2048;
   endfunction

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic put(input int a, input int n, input int re, input int im);
      rx_vec[(a*NBIN + n)*2*DW +: DW]      = DW'(re);
      rx_vec[(a*NBIN + n)*2*DW + DW +: DW] = DW'(im);
   endtask

   task automatic fill_random();
      for (int a = 0; a < NANT; a++)
         for (int n = 0; n < NBIN; n++)
            put(a, n, rand12(), rand12());
   endtask

   task automatic pulse_start();
      start = 1'b1;
      tick(1);
      start = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; rx_vec = '0;
      phase_tag = "R8";
      #1;
      tick(3);
      rst_n = 1'b1;
      tick(2);

      // matched vector: peak expected at delay 5 (R2)
      phase_tag = "R2";
      for (int a = 0; a < NANT; a++)
         for (int n = 0; n < NBIN; n++)
            put(a, n, ref_c_re(5, n), -ref_c_im(5, n));
      pulse_start();
      tick(72);

      // full-scale headroom (R3)
      phase_tag = "R3";
      for (int a = 0; a < NANT; a++)
         for (int n = 0; n < NBIN; n++)
            put(a, n, -2048, -2048);
      pulse_start();
      tick(72);

      // single-bin impulse on antenna 2, bin 9 (R2)
      phase_tag = "R2";
      rx_vec = '0;
      put(2, 9, 1000, -700);
      pulse_start();
      tick(72);

      // pseudo-random vector (R4)
      phase_tag = "R4";
      fill_random();
      pulse_start();
      tick(72);

      // input changed in mid-run must not disturb results (R1)
      phase_tag = "R1";
      fill_random();
      pulse_start();
      tick(10);
      fill_random();
      tick(62);

      // start during a run ignored, last ignored edge, then back-to-back accept (R7)
      phase_tag = "R7";
      fill_random();
      pulse_start();
      tick(19);
      fill_random();
      pulse_start();
      tick(43);
      pulse_start();
      pulse_start();
      tick(72);

      // reset in mid-run abandons the run (R8)
      phase_tag = "R8";
      fill_random();
      pulse_start();
      tick(30);
      rst_n = 1'b0;
      tick(2);
      rst_n = 1'b1;
      tick(75);
      fill_random();
      pulse_start();
      tick(72);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule